// File: doc/BRIEF.md
# Sleep State Power Mode Controller

This block moves a power-management device between an awake state and a low-power sleep state. The trigger is one external sleep request pin. The pin is not debounced. It passes through a short synchronizer, and each qualifying edge of the synchronized signal acts at once. A polarity bit chooses which edge direction means "go to sleep". The other edge direction always means "wake up". A set of sleep-blocking flags can veto the entry into sleep.

While the device sleeps, every power resource drops to its low-power or off mode. The exception is a resource whose bit is set in one of two keep-awake masks. One mask covers the linear regulators and the other covers the remaining resources. One bit of the second mask also decides whether the 32 kHz clock output keeps running. Four general-purpose outputs take a programmed level for each state, so that external loads can be switched when the device sleeps. All register values arrive as plain parallel inputs.

Top module: `sleep_mode_ctrl`

## Requirements
- R1: After reset the state is awake (`inSleep`=0), every bit of `ldoActive` and `resActive` is 1, `clkOutEn` is 1 and `gpoLevel` is 0.
- R2: With `polInv`=0, a falling edge of `sleepReq` enters sleep and a rising edge returns to awake.
- R3: With `polInv`=1, a rising edge enters sleep and a falling edge returns to awake. A change of `polInv` on its own never causes a transition.
- R4: An entry edge that arrives while any bit of `sleepBlock` is 1 is discarded. The state stays awake after the flags clear, until a new entry edge arrives.
- R5: An exit edge always returns the device to awake, whatever the state of `sleepBlock`.
- R6: In sleep, `ldoActive[i]` equals `keepLdo[i]`. While awake, every bit of `ldoActive` is 1.
- R7: In sleep, `resActive[j]` equals `keepRes[j]`. While awake, every bit of `resActive` is 1.
- R8: `clkOutEn` is 1 while awake. In sleep it equals `keepRes[5]`, which is the clock-output keep bit.
- R9: Bit k of `gpoLevel` drives GPO 0, 6, 7 and 8 for k = 0, 1, 2 and 3. Each bit takes `gpoSleepLvl[k]` in sleep and `gpoAwakeLvl[k]` while awake.
- R10: A change of `sleepReq` made just before clock edge 1 sets `inSleep` at edge 3, and the resource, clock and GPO outputs follow at edge 4.
- R11: A change of a mask or level input shows on the outputs one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | External sleep request pin, asynchronous |
| polInv | input | 1 | 1 inverts the sense of the sleep edges |
| sleepBlock | input | 3 | Sleep-blocking flags; any 1 vetoes sleep entry |
| keepLdo | input | 8 | Keep-awake mask for the linear regulators |
| keepRes | input | 6 | Keep-awake mask for the other resources; bit 5 is the clock output |
| gpoSleepLvl | input | 4 | GPO levels used in sleep |
| gpoAwakeLvl | input | 4 | GPO levels used while awake |
| inSleep | output | 1 | 1 while in the sleep state |
| ldoActive | output | 8 | 1 = regulator in full active mode, 0 = low power or off |
| resActive | output | 6 | 1 = resource in full active mode, 0 = low power or off |
| clkOutEn | output | 1 | Enable for the 32 kHz clock output |
| gpoLevel | output | 4 | Levels for GPO 0, 6, 7 and 8 |

## Verification
Two events can fall in the same cycle: a sleep-entry edge on the synchronized pin and an active blocking flag. The bench provokes this by raising a blocking flag before it drives the entry edge and holding the flag through the whole synchronizer latency. It then judges the result by checking that the device is still awake, and that it stays awake after the flag clears. The inverse case is an exit edge that arrives while a blocking flag is set; the bench checks that this edge is still honoured. Mask changes are also made during sleep, and the bench checks that the outputs follow one edge later.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic {ST_AWAKE = 1'b0, ST_SLEEP = 1'b1} slp_state_t;

  typedef struct packed {
    logic enterSleep;
    logic exitSleep;
    logic sleeping;
  } slp_strobe_t;
endpackage

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
#(
  parameter int NUM_BLOCK   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sleepReq,
  input  logic                 polInv,
  input  logic [NUM_BLOCK-1:0] sleepBlock,
  output slp_strobe_t          strb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;
  logic effNow, effPrev, enterEdge, exitEdge, blocked;
  slp_state_t stateQ, stateD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= '1;
      prevQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], sleepReq};
      prevQ <= syncQ[LAST];
    end
  end

  // Both samples use the present polarity, so a polarity change alone makes no edge.
  assign effNow    = syncQ[LAST] ^ polInv;
  assign effPrev   = prevQ ^ polInv;
  assign enterEdge = effPrev & ~effNow;
  assign exitEdge  = ~effPrev & effNow;
  assign blocked   = |sleepBlock;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_AWAKE: if (enterEdge && !blocked) stateD = ST_SLEEP;
      ST_SLEEP: if (exitEdge) stateD = ST_AWAKE;
      default:  stateD = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_AWAKE;
    else        stateQ <= stateD;
  end

  assign strb.enterSleep = enterEdge;
  assign strb.exitSleep  = exitEdge;
  assign strb.sleeping   = (stateQ == ST_SLEEP);

  // R4: a blocking flag holds the device awake
  a_r4_block_holds_awake: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_AWAKE && blocked) |=> (stateQ == ST_AWAKE));
  // R5: an exit edge in sleep always wakes
  a_r5_exit_honoured: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_SLEEP && exitEdge) |=> (stateQ == ST_AWAKE));
  // R2: sleep is entered only on an entry edge
  a_r2_entry_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_AWAKE && !enterEdge) |=> (stateQ == ST_AWAKE));
endmodule

// File: rtl/slp_datapath.sv
module slp_datapath
  import slp_pkg::*;
#(
  parameter int NUM_LDO = 8,
  parameter int NUM_RES = 6,
  parameter int CLK_BIT = 5,
  parameter int NUM_GPO = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  slp_strobe_t        strb,
  input  logic [NUM_LDO-1:0] keepLdo,
  input  logic [NUM_RES-1:0] keepRes,
  input  logic [NUM_GPO-1:0] gpoSleepLvl,
  input  logic [NUM_GPO-1:0] gpoAwakeLvl,
  output logic [NUM_LDO-1:0] ldoActive,
  output logic [NUM_RES-1:0] resActive,
  output logic               clkOutEn,
  output logic [NUM_GPO-1:0] gpoLevel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldoActive <= '1;
      resActive <= '1;
      clkOutEn  <= 1'b1;
    end else begin
      ldoActive <= strb.sleeping ? keepLdo : '1;
      resActive <= strb.sleeping ? keepRes : '1;
      clkOutEn  <= !strb.sleeping || keepRes[CLK_BIT];
    end
  end

  for (genvar k = 0; k < NUM_GPO; k++) begin : g_gpo
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gpoLevel[k] <= 1'b0;
      else        gpoLevel[k] <= strb.sleeping ? gpoSleepLvl[k] : gpoAwakeLvl[k];
    end
  end

  // R6: regulators are fully active one edge after an awake cycle
  a_r6_awake_full: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.sleeping |=> (&ldoActive));
  // R8: the clock output runs one edge after an awake cycle
  a_r8_clk_awake: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.sleeping |=> clkOutEn);
  // R7: in sleep no resource outside the keep mask stays active
  a_r7_sleep_masked: assert property (@(posedge clk) disable iff (!rst_n)
    strb.sleeping |=> ((resActive & ~$past(keepRes)) == '0));
endmodule

// File: rtl/sleep_mode_ctrl.sv
module sleep_mode_ctrl
  import slp_pkg::*;
#(
  parameter int NUM_BLOCK = 3,
  parameter int NUM_LDO   = 8,
  parameter int NUM_RES   = 6,
  parameter int CLK_BIT   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sleepReq,
  input  logic                 polInv,
  input  logic [NUM_BLOCK-1:0] sleepBlock,
  input  logic [NUM_LDO-1:0]   keepLdo,
  input  logic [NUM_RES-1:0]   keepRes,
  input  logic [3:0]           gpoSleepLvl,
  input  logic [3:0]           gpoAwakeLvl,
  output logic                 inSleep,
  output logic [NUM_LDO-1:0]   ldoActive,
  output logic [NUM_RES-1:0]   resActive,
  output logic                 clkOutEn,
  output logic [3:0]           gpoLevel
);
  slp_strobe_t strb;

  slp_ctrl #(.NUM_BLOCK(NUM_BLOCK), .SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sleepReq(sleepReq), .polInv(polInv),
    .sleepBlock(sleepBlock), .strb(strb)
  );

  slp_datapath #(.NUM_LDO(NUM_LDO), .NUM_RES(NUM_RES), .CLK_BIT(CLK_BIT), .NUM_GPO(4)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .keepLdo(keepLdo), .keepRes(keepRes),
    .gpoSleepLvl(gpoSleepLvl), .gpoAwakeLvl(gpoAwakeLvl),
    .ldoActive(ldoActive), .resActive(resActive), .clkOutEn(clkOutEn), .gpoLevel(gpoLevel)
  );

  assign inSleep = strb.sleeping;
endmodule

// File: tb/sim_sleep_mode_ctrl.sv
module sim_sleep_mode_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleepReq = 1'b1;
  logic polInv = 1'b0;
  logic [2:0] sleepBlock = '0;
  logic [7:0] keepLdo = '0;
  logic [5:0] keepRes = '0;
  logic [3:0] gpoSleepLvl = '0;
  logic [3:0] gpoAwakeLvl = '0;
  logic inSleep, clkOutEn;
  logic [7:0] ldoActive;
  logic [5:0] resActive;
  logic [3:0] gpoLevel;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sleep_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sleepReq(sleepReq), .polInv(polInv),
    .sleepBlock(sleepBlock), .keepLdo(keepLdo), .keepRes(keepRes),
    .gpoSleepLvl(gpoSleepLvl), .gpoAwakeLvl(gpoAwakeLvl),
    .inSleep(inSleep), .ldoActive(ldoActive), .resActive(resActive),
    .clkOutEn(clkOutEn), .gpoLevel(gpoLevel)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(inSleep == 1'b0, "R1 inSleep", inSleep, 0);
    chk(ldoActive == 8'hFF, "R1 ldoActive", ldoActive, 8'hFF);
    chk(resActive == 6'h3F, "R1 resActive", resActive, 6'h3F);
    chk(clkOutEn == 1'b1, "R1 clkOutEn", clkOutEn, 1);
    chk(gpoLevel == 4'h0, "R1 gpoLevel", gpoLevel, 0);
  endtask

  task automatic t_default_pol;
    keepLdo = 8'h5A; keepRes = 6'b100001;
    gpoAwakeLvl = 4'b1010; gpoSleepLvl = 4'b0101;
    tick(2);
    chk(gpoLevel == 4'b1010, "R9 awake level", gpoLevel, 4'b1010);
    sleepReq = 1'b0;
    tick(2);
    chk(inSleep == 1'b0, "R10 no state at edge 2", inSleep, 0);
    tick(1);
    chk(inSleep == 1'b1, "R10 state at edge 3", inSleep, 1);
    chk(ldoActive == 8'hFF, "R10 outputs still awake at edge 3", ldoActive, 8'hFF);
    tick(1);
    chk(ldoActive == 8'h5A, "R6 sleep ldo mask", ldoActive, 8'h5A);
    chk(resActive == 6'b100001, "R7 sleep res mask", resActive, 6'b100001);
    chk(clkOutEn == 1'b1, "R8 clock kept", clkOutEn, 1);
    chk(gpoLevel == 4'b0101, "R9 sleep level", gpoLevel, 4'b0101);
    keepRes = 6'b000010; keepLdo = 8'hFF;
    tick(1);
    chk(clkOutEn == 1'b0, "R11 R8 clock gated next edge", clkOutEn, 0);
    chk(resActive == 6'b000010, "R11 res mask next edge", resActive, 6'b000010);
    chk(ldoActive == 8'hFF, "R11 ldo mask next edge", ldoActive, 8'hFF);
    sleepReq = 1'b1;
    tick(4);
    chk(inSleep == 1'b0, "R2 rising edge wakes", inSleep, 0);
    chk(ldoActive == 8'hFF && resActive == 6'h3F, "R7 awake all active",
        {ldoActive, resActive}, {8'hFF, 6'h3F});
    chk(clkOutEn == 1'b1, "R8 clock awake", clkOutEn, 1);
    chk(gpoLevel == 4'b1010, "R9 back to awake level", gpoLevel, 4'b1010);
  endtask

  task automatic t_inverted_pol;
    polInv = 1'b1;
    tick(4);
    chk(inSleep == 1'b0, "R3 polarity change alone", inSleep, 0);
    sleepReq = 1'b0;
    tick(5);
    chk(inSleep == 1'b0, "R3 falling edge while awake", inSleep, 0);
    sleepReq = 1'b1;
    tick(5);
    chk(inSleep == 1'b1, "R3 rising edge enters", inSleep, 1);
    sleepReq = 1'b0;
    tick(5);
    chk(inSleep == 1'b0, "R3 falling edge exits", inSleep, 0);
    polInv = 1'b0; sleepReq = 1'b1;
    tick(5);
  endtask

  task automatic t_block;
    keepLdo = 8'h00;
    sleepBlock = 3'b010;
    sleepReq = 1'b0;
    tick(6);
    chk(inSleep == 1'b0, "R4 blocked entry", inSleep, 0);
    chk(ldoActive == 8'hFF, "R4 outputs stay active", ldoActive, 8'hFF);
    sleepBlock = 3'b000;
    tick(4);
    chk(inSleep == 1'b0, "R4 edge not remembered", inSleep, 0);
    sleepReq = 1'b1;
    tick(5);
    sleepReq = 1'b0;
    tick(5);
    chk(inSleep == 1'b1, "R4 fresh edge enters", inSleep, 1);
    chk(ldoActive == 8'h00, "R6 all ldo low power", ldoActive, 0);
    sleepBlock = 3'b101;
    sleepReq = 1'b1;
    tick(5);
    chk(inSleep == 1'b0, "R5 exit despite block", inSleep, 0);
    sleepBlock = 3'b000;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_default_pol();
    t_inverted_pol();
    t_block();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule